// File: doc/BRIEF.md
# Serial-bus control and status slave for a signal-routing switch

This block is the two-wire serial (I2C) slave that configures an audio/video routing switch. A bus master writes three control bytes that choose the source for each of the three outputs, set the gain and separate/composite choices, and set a DC-level code. The master can also read back two status bytes built from the input detectors. The slave runs on a fast system clock and oversamples SCL and SDA. It drives SDA only by pulling it low, through an output enable. No clock stretching is done.

The seven address bits are a fixed six-bit prefix followed by one bit taken from the `addr_sel` pin. This lets two switches share one bus. A write always fills the control bytes in order, starting at the first. A read always returns a pair of status bytes captured at one instant. The decoded control fields drive the routing logic directly.

Top module: `swctl_slave`

## Requirements
- R1: The slave answers the address byte 1,0,0,1,0,0,S,RW (MSB first), where S equals `addr_sel`, so the write addresses are 0x90 and 0x92. It acknowledges a matching address by holding SDA low during the ninth SCL pulse.
- R2: When the address does not match, the slave gives no acknowledge and ignores all traffic until the next start, and the control fields keep their values.
- R3: After a write address, the first data byte sets {gain_cut, sep_out1, vsel1[2:0], asel1[2:0]} from bit 7 down to bit 0. The second data byte sets {luma_out2, sep_out2, vsel2[2:0], asel2[2:0]} the same way. The slave acknowledges each data byte.
- R4: The third data byte sets sep_out3 from bit 6, avsel3 from bits 5..3 and dc_code from bits 2..1. Bits 7 and 0 of this byte have no effect on any output.
- R5: Data bytes after the third are acknowledged and change no control field.
- R6: After a read address, the slave sends status byte 1 and then status byte 2, MSB first. Both bytes carry {sep_det[0], sep_det[1], sep_det[2], sep_det[3]} in bits 7..4. In bits 3..0, byte 1 carries {aspect[1:0], aspect[3:2]} and byte 2 carries {aspect[5:4], aspect[7:6]}. The slave starts pulling SDA low only while SCL is low.
- R7: If the master NACKs status byte 1, the slave releases SDA (it reads as 1 on every later pulse) until a stop, and the next transfer works normally.
- R8: The status bytes are captured when the read address is acknowledged. A change of `sep_det` or `aspect` after that moment does not appear in either byte of the transfer in progress.
- R9: Reset clears every control field to zero and releases SDA.
- R10: A repeated start ends the current transfer and starts address decoding again, even after an address that did not match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | When 1, the slave pulls SDA low |
| addr_sel | input | 1 | Selects the address LSB |
| sep_det | input | 4 | Separate-input detect flag per input 1..4 |
| aspect | input | 8 | Two-bit aspect code per input, input k at bits 2k+1..2k |
| gain_cut | output | 1 | Output 1 audio gain reduction |
| sep_out1 | output | 1 | Output 1 separate/composite choice |
| vsel1 | output | 3 | Output 1 video source |
| asel1 | output | 3 | Output 1 audio source |
| luma_out2 | output | 1 | Second composite pin carries luma instead of composite |
| sep_out2 | output | 1 | Output 2 separate/composite choice |
| vsel2 | output | 3 | Output 2 video source |
| asel2 | output | 3 | Output 2 audio source |
| sep_out3 | output | 1 | Output 3 separate/composite choice |
| avsel3 | output | 3 | Output 3 combined audio/video source |
| dc_code | output | 2 | DC-level code |

## Verification
The hardest case to reach is the status capture. The detector inputs must change inside a read, after the address acknowledge but before the master has clocked out either byte. The bench drives the read one byte at a time, changes `sep_det` and `aspect` right after the address acknowledge, and expects both bytes to show the old values. The NACK path is also hard to observe, because a silent slave looks the same as a correct one. The bench therefore clocks a further byte after the NACK and expects SDA to read all ones, and then shows with a following write that the slave still answers.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
    localparam int SEL_W  = 3;
    localparam int DC_W   = 2;
    localparam int N_CTRL = 3;
    localparam int N_STAT = 2;
    localparam int N_DET  = 4;
    localparam int ASP_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_IGNORE
    } xfer_st_t;

    typedef struct packed {
        logic             gain_cut;
        logic             sep1;
        logic [SEL_W-1:0] vsel1;
        logic [SEL_W-1:0] asel1;
        logic             luma2;
        logic             sep2;
        logic [SEL_W-1:0] vsel2;
        logic [SEL_W-1:0] asel2;
        logic             sep3;
        logic [SEL_W-1:0] avsel3;
        logic [DC_W-1:0]  dc_code;
    } route_t;
endpackage

// File: rtl/swctl_lines.sv
module swctl_lines #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
    } line_t;

    line_t d, q;

    // Shift chains bring the bus lines into the clock domain; the prev bits give edges.
    always_comb begin
        d          = q;
        d.scl_sh   = {q.scl_sh[SYNC_STAGES-2:0], scl_i};
        d.sda_sh   = {q.sda_sh[SYNC_STAGES-2:0], sda_i};
        d.scl_prev = q.scl_sh[MSB];
        d.sda_prev = q.sda_sh[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_lvl   = q.scl_sh[MSB];
    assign sda_lvl   = q.sda_sh[MSB];
    assign scl_rise  = scl_lvl & ~q.scl_prev;
    assign scl_fall  = ~scl_lvl & q.scl_prev;
    assign start_evt = scl_lvl & q.scl_prev & ~sda_lvl & q.sda_prev;
    assign stop_evt  = scl_lvl & q.scl_prev & sda_lvl & ~q.sda_prev;
endmodule

// File: rtl/swctl_fields.sv
module swctl_fields
    import swctl_pkg::*;
(
    input  logic [N_CTRL*8-1:0]      ctrl_bytes,
    input  logic [N_DET-1:0]         sep_det,
    input  logic [N_DET*ASP_W-1:0]   aspect,
    output route_t                   route,
    output logic [N_STAT*8-1:0]      status_word
);
    logic [7:0] b1, b2, b3;
    logic [N_DET-1:0] flags_rev;
    logic unused_bits;

    assign b1 = ctrl_bytes[7:0];
    assign b2 = ctrl_bytes[15:8];
    assign b3 = ctrl_bytes[23:16];
    assign unused_bits = b3[7] ^ b3[0];

    always_comb begin
        for (int i = 0; i < N_DET; i++) flags_rev[N_DET-1-i] = sep_det[i];
    end

    always_comb begin
        route.gain_cut = b1[7];
        route.sep1     = b1[6];
        route.vsel1    = b1[5:3];
        route.asel1    = b1[2:0];
        route.luma2    = b2[7];
        route.sep2     = b2[6];
        route.vsel2    = b2[5:3];
        route.asel2    = b2[2:0];
        route.sep3     = b3[6];
        route.avsel3   = b3[5:3];
        route.dc_code  = b3[2:1];
    end

    assign status_word = {flags_rev, aspect[1:0], aspect[3:2],
                          flags_rev, aspect[5:4], aspect[7:6]};
endmodule

// File: rtl/swctl_xfer.sv
module swctl_xfer
    import swctl_pkg::*;
#(
    parameter logic [5:0] DEV_PREFIX = 6'b100100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_lvl,
    input  logic                  sda_lvl,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_evt,
    input  logic                  stop_evt,
    input  logic                  addr_sel,
    input  logic [N_STAT*8-1:0]   status_i,
    output logic                  sda_oe,
    output logic [N_CTRL*8-1:0]   ctrl_bytes
);
    localparam int IDX_W = $clog2(N_CTRL + 1);
    localparam logic [IDX_W-1:0] IDX_ONE = 1;

    typedef struct packed {
        xfer_st_t              st;
        logic [3:0]            cnt;
        logic [7:0]            sh;
        logic                  oe;
        logic                  rw;
        logic [IDX_W-1:0]      widx;
        logic                  rsecond;
        logic [N_STAT*8-1:0]   snap;
        logic [N_CTRL*8-1:0]   ctrl;
    } xs_t;

    xs_t d, q;

    function automatic logic [7:0] wmask(int idx);
        return (idx == N_CTRL - 1) ? 8'h7E : 8'hFF;
    endfunction

    always_comb begin
        d = q;
        if (stop_evt) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_evt) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_lvl};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == {DEV_PREFIX, addr_sel}) begin
                                d.st      = ST_AACK;
                                d.oe      = 1'b1;
                                d.rw      = q.sh[0];
                                d.widx    = '0;
                                d.rsecond = 1'b0;
                                if (q.sh[0]) d.snap = status_i;
                            end else begin
                                d.st = ST_IGNORE;
                            end
                        end else begin
                            d.st = ST_WACK;
                            d.oe = 1'b1;
                            if (int'(q.widx) < N_CTRL) begin
                                for (int i = 0; i < N_CTRL; i++)
                                    if (int'(q.widx) == i) d.ctrl[i*8 +: 8] = q.sh & wmask(i);
                                d.widx = q.widx + IDX_ONE;
                            end
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st = ST_RDATA;
                            d.sh = q.snap[15:8];
                            d.oe = ~q.snap[15];
                        end else begin
                            d.st = ST_WDATA;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        d.st  = ST_WDATA;
                        d.oe  = 1'b0;
                        d.cnt = '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = ST_RACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_lvl || q.rsecond) d.st = ST_IGNORE;
                    end else if (scl_fall) begin
                        d.st      = ST_RDATA;
                        d.sh      = q.snap[7:0];
                        d.oe      = ~q.snap[7];
                        d.cnt     = '0;
                        d.rsecond = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe     = q.oe;
    assign ctrl_bytes = q.ctrl;

    // R2/R3: control bytes move only on the cycle after a data byte completes
    a_r2_ctrl_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_WDATA) |=> $stable(q.ctrl));

    // R8: captured status holds outside address decoding
    a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_ADDR) |=> $stable(q.snap));

    // R6: the slave begins pulling SDA low only while SCL is low
    a_r6_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !$past(scl_lvl));

    // R7: a slave that is waiting or ignoring never drives the line
    a_r7_quiet_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGNORE || q.st == ST_IDLE) |-> !q.oe);
endmodule

// File: rtl/swctl_slave.sv
module swctl_slave
    import swctl_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] DEV_PREFIX  = 6'b100100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe,
    input  logic                    addr_sel,
    input  logic [N_DET-1:0]        sep_det,
    input  logic [N_DET*ASP_W-1:0]  aspect,
    output logic                    gain_cut,
    output logic                    sep_out1,
    output logic [SEL_W-1:0]        vsel1,
    output logic [SEL_W-1:0]        asel1,
    output logic                    luma_out2,
    output logic                    sep_out2,
    output logic [SEL_W-1:0]        vsel2,
    output logic [SEL_W-1:0]        asel2,
    output logic                    sep_out3,
    output logic [SEL_W-1:0]        avsel3,
    output logic [DC_W-1:0]         dc_code
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic [N_CTRL*8-1:0] ctrl_bytes;
    logic [N_STAT*8-1:0] status_word;
    route_t route;

    swctl_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    swctl_xfer #(.DEV_PREFIX(DEV_PREFIX)) u_xfer (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
        .stop_evt(stop_evt), .addr_sel(addr_sel), .status_i(status_word),
        .sda_oe(sda_oe), .ctrl_bytes(ctrl_bytes)
    );

    swctl_fields u_fields (
        .ctrl_bytes(ctrl_bytes), .sep_det(sep_det), .aspect(aspect),
        .route(route), .status_word(status_word)
    );

    assign gain_cut  = route.gain_cut;
    assign sep_out1  = route.sep1;
    assign vsel1     = route.vsel1;
    assign asel1     = route.asel1;
    assign luma_out2 = route.luma2;
    assign sep_out2  = route.sep2;
    assign vsel2     = route.vsel2;
    assign asel2     = route.asel2;
    assign sep_out3  = route.sep3;
    assign avsel3    = route.avsel3;
    assign dc_code   = route.dc_code;
endmodule

// File: tb/tb_swctl_slave.sv
`timescale 1ns/1ps
module tb_swctl_slave;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic addr_sel = 1'b0;
    logic [3:0] sep_det = 4'h0;
    logic [7:0] aspect = 8'h00;
    logic sda_oe, sda_w;
    logic gain_cut, sep_out1, luma_out2, sep_out2, sep_out3;
    logic [2:0] vsel1, asel1, vsel2, asel2, avsel3;
    logic [1:0] dc_code;
    int n_chk = 0, n_err = 0;

    always #10 clk = ~clk;
    assign sda_w = m_sda & ~sda_oe;

    swctl_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_w), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .sep_det(sep_det), .aspect(aspect),
        .gain_cut(gain_cut), .sep_out1(sep_out1), .vsel1(vsel1), .asel1(asel1),
        .luma_out2(luma_out2), .sep_out2(sep_out2), .vsel2(vsel2), .asel2(asel2),
        .sep_out3(sep_out3), .avsel3(avsel3), .dc_code(dc_code)
    );

    // {addr_sel, DATA1, DATA2, DATA3}
    localparam logic [24:0] WVEC [4] = '{25'h0A53CFF, 25'h15AC381, 25'h0FFFF7E, 25'h1123456};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wclk(Q); m_scl = 1'b1; wclk(Q);
        m_sda = 1'b0; wclk(Q); m_scl = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wclk(Q); m_scl = 1'b1; wclk(Q); m_sda = 1'b1; wclk(Q);
    endtask

    task automatic bit_io(input logic b, output logic s);
        m_sda = b; wclk(Q); m_scl = 1'b1; wclk(Q); s = sda_w; wclk(Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); b[i] = s; end
        bit_io(~m_ack, s);
    endtask

    function automatic logic [21:0] exp_fields(input logic [7:0] d1, d2, d3);
        return {d1, d2, d3[6:1]};
    endfunction

    function automatic logic [21:0] act_fields();
        return {gain_cut, sep_out1, vsel1, asel1, luma_out2, sep_out2, vsel2, asel2,
                sep_out3, avsel3, dc_code};
    endfunction

    function automatic logic [15:0] exp_stat(input logic [3:0] f, input logic [7:0] a);
        logic [3:0] fl;
        fl = {f[0], f[1], f[2], f[3]};
        return {fl, a[1:0], a[3:2], fl, a[5:4], a[7:6]};
    endfunction

    initial begin
        wclk(200000);
        n_err++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic a0, a1, a2, a3, a4;
        logic [7:0] r1, r2;
        logic [21:0] keep;
        wclk(5);
        // R9: reset state
        chk("R9 fields after reset", 32'(act_fields()), 32'h0);
        chk("R9 sda released in reset", 32'(sda_oe), 32'h0);
        rst_n = 1'b1;
        wclk(5);

        // R1/R3/R4: vector table of writes
        for (int v = 0; v < 4; v++) begin
            addr_sel = WVEC[v][24];
            bus_start();
            send_byte(addr_sel ? 8'h92 : 8'h90, a0);
            send_byte(WVEC[v][23:16], a1);
            send_byte(WVEC[v][15:8], a2);
            send_byte(WVEC[v][7:0], a3);
            bus_stop();
            wclk(4);
            chk("R1 R3 acks on write", 32'({a0, a1, a2, a3}), 32'hF);
            chk("R3 R4 fields after write", 32'(act_fields()),
                32'(exp_fields(WVEC[v][23:16], WVEC[v][15:8], WVEC[v][7:0])));
        end
        // now addr_sel = 1, fields from 12/34/56
        keep = exp_fields(8'h12, 8'h34, 8'h56);

        // R2: wrong address ignored
        addr_sel = 1'b0;
        bus_start();
        send_byte(8'h92, a0);
        send_byte(8'hFF, a1);
        send_byte(8'hFF, a2);
        bus_stop();
        wclk(4);
        chk("R2 no ack on mismatch", 32'({a0, a1, a2}), 32'h0);
        chk("R2 fields unchanged", 32'(act_fields()), 32'(keep));

        // R5: extra data bytes acked and discarded
        bus_start();
        send_byte(8'h90, a0);
        send_byte(8'h81, a1);
        send_byte(8'h42, a2);
        send_byte(8'h24, a3);
        send_byte(8'hFF, a4);
        bus_stop();
        wclk(4);
        chk("R5 extra byte acked", 32'({a0, a1, a2, a3, a4}), 32'h1F);
        chk("R5 fields from first three", 32'(act_fields()), 32'(exp_fields(8'h81, 8'h42, 8'h24)));

        // R6: two-byte read at addr_sel=1
        addr_sel = 1'b1;
        sep_det = 4'b1001; aspect = 8'b11_10_01_00;
        bus_start();
        send_byte(8'h93, a0);
        recv_byte(1'b1, r1);
        recv_byte(1'b0, r2);
        bus_stop();
        chk("R1 R6 read address ack", 32'(a0), 32'h1);
        chk("R6 status bytes", 32'({r1, r2}), 32'(exp_stat(4'b1001, 8'b11_10_01_00)));

        // R8: snapshot at address ack
        addr_sel = 1'b0;
        sep_det = 4'b0110; aspect = 8'b00_01_10_11;
        bus_start();
        send_byte(8'h91, a0);
        sep_det = 4'b1100; aspect = 8'b10_10_01_01;
        recv_byte(1'b1, r1);
        recv_byte(1'b0, r2);
        bus_stop();
        chk("R8 snapshot both bytes", 32'({r1, r2}), 32'(exp_stat(4'b0110, 8'b00_01_10_11)));

        // R7: NACK after first byte releases the line
        bus_start();
        send_byte(8'h91, a0);
        recv_byte(1'b0, r1);
        recv_byte(1'b0, r2);
        bus_stop();
        chk("R7 first byte before nack", 32'(r1), 32'(exp_stat(4'b1100, 8'b10_10_01_01) >> 8));
        chk("R7 line released after nack", 32'(r2), 32'hFF);
        bus_start();
        send_byte(8'h90, a0);
        send_byte(8'h11, a1);
        send_byte(8'h22, a2);
        send_byte(8'h44, a3);
        bus_stop();
        wclk(4);
        chk("R7 next write works", 32'({a0, a1, a2, a3, act_fields()}),
            32'({4'hF, exp_fields(8'h11, 8'h22, 8'h44)}));

        // R10: repeated start after mismatch
        bus_start();
        send_byte(8'h92, a0);
        bus_start();
        send_byte(8'h90, a1);
        send_byte(8'hC9, a2);
        send_byte(8'h9C, a3);
        send_byte(8'h3A, a4);
        bus_stop();
        wclk(4);
        chk("R10 mismatch then match acks", 32'({a0, a1, a2, a3, a4}), 32'h0F);
        chk("R10 fields after restart", 32'(act_fields()), 32'(exp_fields(8'hC9, 8'h9C, 8'h3A)));

        // R9: reset clears again
        rst_n = 1'b0;
        wclk(3);
        chk("R9 fields after second reset", 32'(act_fields()), 32'h0);
        rst_n = 1'b1;
        wclk(3);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule